// File: doc/BRIEF.md
# Calendar Clock Register Window

This block keeps a second-by-second calendar (seconds, minutes, hours, weekday, day of month, month, two-digit year) in packed BCD and presents it to software as eight bytes at the very top of a byte-wide address space. A one-second pulse from an external divider drives a set of live counters. Software never reads those counters directly. It sees a set of holding bytes that are refreshed from the counters as one group, one cycle after each counting step.

A control byte at the lowest address of the window gives software two ways to stop that refresh. A freeze bit holds a consistent snapshot for reading while the counters keep running. A set bit also stops the refresh and lets software write a new time into the holding bytes; clearing it copies all seven time bytes into the counters at once. The same control byte carries a six-bit calibration setting for the divider, and a flag in the weekday byte enables a frequency test output. Both are passed on as outputs.

Top module: `rtc_window`

## Requirements
- R1: After reset the window reads control 0x00, seconds 0x80 (halt bit set, 00 s), minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01 and year 0x00. `ft_en` and `cal_setting` are 0, and a read outside the window returns 0x00.
- R2: The window is the eight addresses whose upper bits are all ones. Its low three address bits select control (0), seconds (1), minutes (2), hours (3), weekday (4), day of month (5), month (6) and year (7).
- R3: Undefined bits are stored and read as zero. The write masks are seconds 0xFF, minutes 0x7F, hours 0x3F, weekday 0x47, day 0x3F, month 0x1F, year 0xFF and control 0xFF.
- R4: While bit 7 of the live seconds byte (the halt bit) is 1, a tick does not advance the counters.
- R5: A tick with the halt bit at 0 advances the time by one second. The new time is readable from the second clock edge after the tick cycle.
- R6: A carry ripples through seconds, minutes, hours, weekday and day, month and year within one tick. Seconds and minutes wrap 59 to 00, hours 23 to 00, weekday 7 to 1, month 12 to 01 and year 99 to 00.
- R7: The day of month wraps after 30 in April, June, September and November and after 31 in the other long months. February wraps after 29 when the BCD year is divisible by four (00 included) and after 28 otherwise.
- R8: While control bit 6 (freeze) is 1, the holding bytes keep the snapshot and the counters keep running. After freeze clears, the next tick shows the advanced time.
- R9: While control bit 7 (set) is 1, refresh stops and writes land in the holding bytes. A control write that clears bit 7 while it is 1 copies all seven time bytes into the counters.
- R10: A time-byte write made while freeze and set are both 0 reads back at once, is replaced at the next refresh, and has no effect on the counters.
- R11: `cal_setting` follows control bits 5..0. `ft_en` follows bit 6 of the live weekday byte, which is loaded through the set sequence.
- R12: A refresh that falls in the same cycle as the write setting freeze still completes. Later ticks are then frozen out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 8 | Read data for the addressed window byte, 0 outside |
| ft_en | output | 1 | Frequency test enable from the live weekday byte |
| cal_setting | output | 6 | Calibration sign and magnitude from the control byte |

## Verification
Random valid times are loaded through the set sequence. Each field is biased toward its last value, so that single-step, multi-step and full-chain carries are told apart from a plain seconds count. Directed February, thirty-day and year-end cases separate the leap rule for years 00, 24 and 23 and the month-length table. Freeze, set and plain-write sequences, including a freeze written in the same cycle as a refresh, separate holding-byte behaviour from live-counter behaviour.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam logic [7:0] M_SEC  = 8'hFF;
  localparam logic [7:0] M_MIN  = 8'h7F;
  localparam logic [7:0] M_HR   = 8'h3F;
  localparam logic [7:0] M_DOW  = 8'h47;
  localparam logic [7:0] M_DATE = 8'h3F;
  localparam logic [7:0] M_MON  = 8'h1F;
  localparam logic [7:0] M_YR   = 8'hFF;

  localparam rtc_time_t RST_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                     dow: 8'h01, hr: 8'h00, min: 8'h00,
                                     sec: 8'h80};

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else r = v + 8'd1;
    return r;
  endfunction

  function automatic logic [5:0] last_day(logic [4:0] mon, logic [7:0] yr);
    logic [6:0] yb;
    logic [5:0] r;
    yb = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      5'h02: r = (yb[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default: r = 6'h31;
    endcase
    return r;
  endfunction

  function automatic rtc_time_t rtc_advance(rtc_time_t c);
    rtc_time_t n;
    logic [7:0] t;
    logic cs, cm, ch, cd, cmo;
    n = c;
    cs = (c.sec[6:0] >= 7'h59);
    t = bcd_inc({1'b0, c.sec[6:0]});
    n.sec[6:0] = cs ? 7'h00 : t[6:0];
    cm = cs && (c.min[6:0] >= 7'h59);
    if (cs) begin
      t = bcd_inc({1'b0, c.min[6:0]});
      n.min[6:0] = cm ? 7'h00 : t[6:0];
    end
    ch = cm && (c.hr[5:0] >= 6'h23);
    if (cm) begin
      t = bcd_inc({2'b00, c.hr[5:0]});
      n.hr[5:0] = ch ? 6'h00 : t[5:0];
    end
    cd = ch && (c.date[5:0] >= last_day(c.mon[4:0], c.yr));
    if (ch) begin
      n.dow[2:0] = (c.dow[2:0] >= 3'd7) ? 3'd1 : c.dow[2:0] + 3'd1;
      t = bcd_inc({2'b00, c.date[5:0]});
      n.date[5:0] = cd ? 6'h01 : t[5:0];
    end
    cmo = cd && (c.mon[4:0] >= 5'h12);
    if (cd) begin
      t = bcd_inc({3'b000, c.mon[4:0]});
      n.mon[4:0] = cmo ? 5'h01 : t[4:0];
    end
    if (cmo) n.yr = (c.yr >= 8'h99) ? 8'h00 : bcd_inc(c.yr);
    return n;
  endfunction

endpackage

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load_en,
  input  rtc_time_t load_val,
  output rtc_time_t live
);

  rtc_time_t live_q, live_d;
  logic      adv_en;

  assign adv_en = tick && !live_q.sec[7];

  always_comb begin
    live_d = live_q;
    if (load_en) live_d = load_val;
    else if (adv_en) live_d = rtc_advance(live_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= RST_TIME;
    else if (load_en || adv_en) live_q <= live_d;
  end

  assign live = live_q;

endmodule

// File: rtl/rtc_holding.sv
module rtc_holding
  import rtc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wdata,
  input  rtc_time_t        live,
  output rtc_time_t        hold,
  output logic [7:0]       ctrl,
  output logic             load_go
);

  rtc_time_t  hold_q, hold_d;
  logic [7:0] ctrl_q, ctrl_d;
  logic       upd_q;
  logic       halted;

  assign halted  = ctrl_q[7] | ctrl_q[6];
  assign load_go = wr_en && (wr_idx == '0) && ctrl_q[7] && !wdata[7];

  always_comb begin
    hold_d = hold_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (wr_idx)
        3'd0: ctrl_d      = wdata;
        3'd1: hold_d.sec  = wdata & M_SEC;
        3'd2: hold_d.min  = wdata & M_MIN;
        3'd3: hold_d.hr   = wdata & M_HR;
        3'd4: hold_d.dow  = wdata & M_DOW;
        3'd5: hold_d.date = wdata & M_DATE;
        3'd6: hold_d.mon  = wdata & M_MON;
        default: hold_d.yr = wdata & M_YR;
      endcase
    end
    if (upd_q && !halted) hold_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= RST_TIME;
      ctrl_q <= 8'h00;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= tick;
      if (wr_en || upd_q) begin
        hold_q <= hold_d;
        ctrl_q <= ctrl_d;
      end
    end
  end

  assign hold = hold_q;
  assign ctrl = ctrl_q;

endmodule

// File: rtl/rtc_window.sv
module rtc_window
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  output logic [7:0]        rdata,
  output logic              ft_en,
  output logic [5:0]        cal_setting
);

  localparam int IDX_W = 3;

  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic             wr_en;
  logic             load_go;
  logic [7:0]       ctrl_q;
  rtc_time_t        live;
  rtc_time_t        hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign win_hit = &addr[ADDR_W-1:IDX_W];
  assign win_idx = addr[IDX_W-1:0];
  assign wr_en   = we && win_hit;

  rtc_counters u_cnt (
    .clk(clk), .rst_n(rst_core_n), .tick(tick),
    .load_en(load_go), .load_val(hold), .live(live)
  );

  rtc_holding #(.IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_core_n), .tick(tick),
    .wr_en(wr_en), .wr_idx(win_idx), .wdata(wdata),
    .live(live), .hold(hold), .ctrl(ctrl_q), .load_go(load_go)
  );

  always_comb begin
    rdata = 8'h00;
    if (win_hit) begin
      case (win_idx)
        3'd0: rdata = ctrl_q;
        3'd1: rdata = hold.sec;
        3'd2: rdata = hold.min;
        3'd3: rdata = hold.hr;
        3'd4: rdata = hold.dow;
        3'd5: rdata = hold.date;
        3'd6: rdata = hold.mon;
        default: rdata = hold.yr;
      endcase
    end
  end

  assign ft_en       = live.dow[6];
  assign cal_setting = ctrl_q[5:0];

endmodule

// File: rtl/rtc_window_chk.sv
module rtc_window_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] win_idx,
  input logic       load_go,
  input logic [7:0] ctrl_q,
  input rtc_time_t  live,
  input rtc_time_t  hold
);

  // R4
  halt_bit_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live.sec[7] && !load_go) |=> $stable(live));

  // R10
  cnt_only_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_go) |=> $stable(live));

  // R5
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !live.sec[7] && !load_go) |=> (live != $past(live)));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !(wr_en && win_idx != 3'd0)) |=> $stable(hold));

  // R9
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (live == $past(hold)));

  // R3
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold.min[7] == 1'b0) && (hold.hr[7:6] == 2'b00) && (hold.dow[7] == 1'b0) &&
    (hold.dow[5:3] == 3'b000) && (hold.date[7:6] == 2'b00) && (hold.mon[7:5] == 3'b000));

endmodule

bind rtc_window rtc_window_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .tick(tick), .wr_en(wr_en),
  .win_idx(win_idx), .load_go(load_go), .ctrl_q(ctrl_q),
  .live(live), .hold(hold)
);

// File: tb/rtc_window_test.sv
module rtc_window_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam logic [ADDR_W-1:0] BASE = 13'h1FF8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic              we = 1'b0;
  logic [7:0]        rdata;
  logic              ft_en;
  logic [5:0]        cal_setting;

  int n_run = 0;
  int n_fail = 0;
  int mt[8];   // model: 1 sec .. 7 yr (binary)
  logic [7:0] rv;

  rtc_window #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
    .we(we), .rdata(rdata), .ft_en(ft_en), .cal_setting(cal_setting)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic model_step();
    mt[1]++;
    if (mt[1] == 60) begin mt[1] = 0; mt[2]++; end
    if (mt[2] == 60) begin mt[2] = 0; mt[3]++; end
    if (mt[3] == 24) begin
      mt[3] = 0;
      mt[4] = (mt[4] == 7) ? 1 : mt[4] + 1;
      mt[5]++;
      if (mt[5] > days_in(mt[6], mt[7])) begin
        mt[5] = 1; mt[6]++;
        if (mt[6] == 13) begin mt[6] = 1; mt[7] = (mt[7] + 1) % 100; end
      end
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [7:0] d);
    @(negedge clk);
    addr = BASE + ADDR_W'(idx); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int idx, output logic [7:0] d);
    @(negedge clk);
    addr = BASE + ADDR_W'(idx);
    #1 d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_model(logic [7:0] extra_dow);
    wr(0, 8'h80);
    for (int i = 1; i < 8; i++)
      wr(i, (i == 4) ? (to_bcd(mt[i]) | extra_dow) : to_bcd(mt[i]));
    wr(0, 8'h00);
  endtask

  task automatic cmp_all(string req);
    logic [7:0] d;
    for (int i = 1; i < 8; i++) begin
      rd(i, d);
      check(d == to_bcd(mt[i]), req, d, to_bcd(mt[i]));
    end
  endtask

  task automatic set_t(int s, int m, int h, int dw, int dt, int mo, int y);
    mt[1] = s; mt[2] = m; mt[3] = h; mt[4] = dw; mt[5] = dt; mt[6] = mo; mt[7] = y;
  endtask

  task automatic directed_roll(string req, int dt, int mo, int y);
    set_t(59, 59, 23, 7, dt, mo, y);
    load_model(8'h00);
    do_tick();
    model_step();
    cmp_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] exp_r[8];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values, R2 window order
    exp_r = '{8'h00, 8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    for (int i = 0; i < 8; i++) begin
      rd(i, rv);
      check(rv == exp_r[i], "R1/R2 reset window", rv, exp_r[i]);
    end
    check(ft_en == 1'b0, "R1 ft_en", ft_en, 0);
    check(cal_setting == 6'h00, "R1 cal_setting", cal_setting, 0);
    @(negedge clk); addr = 13'h0005; #1;
    check(rdata == 8'h00, "R1 outside window", rdata, 0);

    // R4 halt bit set at reset: ticks do not advance
    do_tick(); do_tick();
    rd(1, rv);
    check(rv == 8'h80, "R4 halted seconds", rv, 8'h80);

    // R3 masks
    wr(0, 8'h80);
    wr(2, 8'hFF); rd(2, rv); check(rv == 8'h7F, "R3 minutes mask", rv, 8'h7F);
    wr(3, 8'hFF); rd(3, rv); check(rv == 8'h3F, "R3 hours mask", rv, 8'h3F);
    wr(4, 8'hFF); rd(4, rv); check(rv == 8'h47, "R3 weekday mask", rv, 8'h47);
    wr(5, 8'hFF); rd(5, rv); check(rv == 8'h3F, "R3 day mask", rv, 8'h3F);
    wr(6, 8'hFF); rd(6, rv); check(rv == 8'h1F, "R3 month mask", rv, 8'h1F);
    wr(0, 8'h00);

    // R9 load and R5 single tick
    set_t(10, 20, 12, 3, 15, 6, 42);
    load_model(8'h00);
    cmp_all("R9 loaded time");
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; addr = BASE + 1; #1;
    check(rdata == 8'h10, "R5 not yet visible", rdata, 8'h10);
    @(negedge clk); #1;
    check(rdata == 8'h11, "R5 visible after refresh", rdata, 8'h11);
    model_step();

    // R11 calibration and frequency-test outputs
    wr(0, 8'h25);
    check(cal_setting == 6'h25, "R11 cal_setting", cal_setting, 6'h25);
    load_model(8'h40);
    check(ft_en == 1'b1, "R11 ft_en set", ft_en, 1);
    load_model(8'h00);
    check(ft_en == 1'b0, "R11 ft_en clear", ft_en, 0);

    // R10 plain write: visible, replaced, counters untouched
    wr(2, 8'h33);
    rd(2, rv); check(rv == 8'h33, "R10 write visible", rv, 8'h33);
    do_tick(); model_step();
    cmp_all("R10 write replaced");

    // R8 freeze
    wr(0, 8'h40);
    do_tick(); do_tick(); do_tick();
    rd(1, rv); check(rv == to_bcd(mt[1]), "R8 frozen", rv, to_bcd(mt[1]));
    model_step(); model_step(); model_step();
    wr(0, 8'h00);
    do_tick(); model_step();
    cmp_all("R8 resumed");

    // R12 refresh in progress beats freeze write
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; addr = BASE; wdata = 8'h40; we = 1'b1;
    @(negedge clk); we = 1'b0;
    model_step();
    cmp_all("R12 refresh completed");
    do_tick(); model_step();
    rd(1, rv);
    check(rv != to_bcd(mt[1]), "R12 later tick frozen", rv, to_bcd(mt[1]) - 1);
    wr(0, 8'h00);

    // R6 / R7 directed rollovers
    directed_roll("R7 Feb 28 year 23", 28, 2, 23);
    directed_roll("R7 Feb 28 year 24", 28, 2, 24);
    directed_roll("R7 Feb 29 year 24", 29, 2, 24);
    directed_roll("R7 Feb 28 year 00", 28, 2, 0);
    directed_roll("R7 Apr 30", 30, 4, 55);
    directed_roll("R7 Jul 31", 31, 7, 8);
    directed_roll("R6 year end 99", 31, 12, 99);

    // R6 random times biased toward field limits
    for (int it = 0; it < 40; it++) begin
      int nt;
      mt[1] = ($urandom % 2) ? 59 : $urandom % 60;
      mt[2] = ($urandom % 2) ? 59 : $urandom % 60;
      mt[3] = ($urandom % 2) ? 23 : $urandom % 24;
      mt[4] = 1 + $urandom % 7;
      mt[6] = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
      mt[7] = ($urandom % 3 == 0) ? 99 : $urandom % 100;
      mt[5] = ($urandom % 2) ? days_in(mt[6], mt[7]) : 1 + $urandom % days_in(mt[6], mt[7]);
      load_model(8'h00);
      nt = 1 + $urandom % 3;
      for (int k = 0; k < nt; k++) begin do_tick(); model_step(); end
      cmp_all("R6 random carry");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule